// File: doc/BRIEF.md
# Bidirectional GPIO Port with Weak Pull-ups

An eight-pin general-purpose I/O port that sits on a small register bus. Software writes an output latch, a per-pin direction register, an option register whose top bit is an active-low master control for weak pull-ups, and a one-bit analog-mode control for pin 2. The port drives a tri-state pad model made of three registered vectors: the value to drive, the output enable, and the pull-up enable. Reading the port returns the pin levels after a two-stage synchronizer, not the output latch.

The synchronized levels of pins 0 and 1 also leave the block as taps for an external interrupt input and for a serial slave-select input. When pin 2 is in analog mode, its digital read value is forced to 0 and a flag tells the converter that the pin belongs to it.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset, every direction bit is 1, the output latch is 0x00, the pull-up master bit is 1 and analog mode is off. As a result pad_oe, pad_pu and pad_out are all 0x00.
- R2: Direction bit 1 makes a pin an input (pad_oe bit 0). Direction bit 0 makes it an output (pad_oe bit 1, and pad_out carries the latch bit). Writing 0xCF gives pad_oe = 0x30.
- R3: A write to the data register (address 0) updates the latch even for pins that are inputs. The latched value reaches an output pin as soon as that pin is switched to output.
- R4: pad_pu for a pin is 1 only when the pin is an input and the master bit is 0. An output pin is never pulled up.
- R5: The pull-up master control is bit 7 of the option register (address 2). It is active low, resets to 1 and reads back as 0x80 after reset. The other option bits read as 0.
- R6: Address 0 reads the synchronized pin levels and not the latch. Address 1 reads the direction register. Address 3 reads the analog-mode bit in bit 0.
- R7: irq_tap follows the synchronized level of pin 0, and ss_tap follows the synchronized level of pin 1.
- R8: When analog mode is set (address 3, bit 0 = 1), bit 2 of a port read is 0 whatever the pin level, and ana_sel is 1.
- R9: bus_rdata is registered. It shows the register selected by bus_addr one clock edge after the address is presented. Pad outputs change one edge after the register write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 option, 3 analog |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Value driven onto output pins |
| pad_oe | output | 8 | Output enable per pin |
| pad_pu | output | 8 | Weak pull-up enable per pin |
| irq_tap | output | 1 | Synchronized pin 0 level for the interrupt input |
| ss_tap | output | 1 | Synchronized pin 1 level for the slave-select input |
| ana_sel | output | 1 | Pin 2 is routed to the converter |

## Verification
The assertions assume that reset is held for at least one clock edge before any write. They also assume that bus_addr and bus_wr are stable around the rising edge, so that a write is seen on exactly one edge. The bench drives every input on the falling edge, raises bus_wr for a single cycle per access, and changes pad_in only after enough edges have passed for the synchronizer and the read register to settle before the next check.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_PINS = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_OPT  = 2'd2,
    SEL_ANA  = 2'd3
  } reg_sel_e;

  localparam int OPT_PULL_BIT = 7;
  localparam int ANA_EN_BIT   = 0;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pins_rd,
  output logic [W-1:0] rdata,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] dir_q,
  output logic         pull_n_q,
  output logic         ana_q
);
  reg_sel_e     sel;
  logic [W-1:0] rd_mux;

  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q    <= '0;
      dir_q    <= '1;
      pull_n_q <= 1'b1;
      ana_q    <= 1'b0;
    end else if (wr) begin
      case (sel)
        SEL_PINS: lat_q    <= wdata;
        SEL_DIR:  dir_q    <= wdata;
        SEL_OPT:  pull_n_q <= wdata[OPT_PULL_BIT];
        SEL_ANA:  ana_q    <= wdata[ANA_EN_BIT];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_PINS: rd_mux = pins_rd;
      SEL_DIR:  rd_mux = dir_q;
      SEL_OPT:  rd_mux[OPT_PULL_BIT] = pull_n_q;
      SEL_ANA:  rd_mux[ANA_EN_BIT] = ana_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (dir_q == '1 && lat_q == '0 && pull_n_q && !ana_q)); // R1
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == SEL_DIR) |=> dir_q == $past(wdata)); // R2
  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == SEL_PINS) |=> lat_q == $past(wdata)); // R3
  AST_DIR_READ: assert property (@(posedge clk) disable iff (rst)
    (!wr && addr == SEL_DIR) |=> rdata == dir_q); // R9
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int W       = 8,
  parameter int IRQ_PIN = 0,
  parameter int SS_PIN  = 1,
  parameter int ANA_PIN = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lat,
  input  logic [W-1:0] dir,
  input  logic         pull_n,
  input  logic         ana,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] pins_rd,
  output logic         irq_tap,
  output logic         ss_tap,
  output logic         ana_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pad_pu  <= '0;
    end else begin
      pad_out <= lat;
      pad_oe  <= ~dir;
      pad_pu  <= dir & {W{~pull_n}};
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_rd
    if (i == ANA_PIN) begin : g_ana
      assign pins_rd[i] = pin_sync[i] & ~ana;
    end else begin : g_dig
      assign pins_rd[i] = pin_sync[i];
    end
  end

  assign irq_tap = pin_sync[IRQ_PIN];
  assign ss_tap  = pin_sync[SS_PIN];
  assign ana_sel = ana;

  AST_PULL_ON_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & pad_pu) == '0); // R4
  AST_PULL_MASTER_OFF: assert property (@(posedge clk) disable iff (rst)
    pull_n |=> pad_pu == '0); // R4
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_PIN     = 0,
  parameter int SS_PIN      = 1,
  parameter int ANA_PIN     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic         irq_tap,
  output logic         ss_tap,
  output logic         ana_sel
);
  logic [W-1:0] lat_q, dir_q, pin_sync, pins_rd;
  logic         pull_n_q, ana_q;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .pins_rd(pins_rd), .rdata(bus_rdata), .lat_q(lat_q), .dir_q(dir_q),
    .pull_n_q(pull_n_q), .ana_q(ana_q)
  );

  gpio_pad_ctl #(.W(W), .IRQ_PIN(IRQ_PIN), .SS_PIN(SS_PIN), .ANA_PIN(ANA_PIN)) u_pad (
    .clk(clk), .rst(rst), .lat(lat_q), .dir(dir_q), .pull_n(pull_n_q),
    .ana(ana_q), .pin_sync(pin_sync), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pins_rd(pins_rd), .irq_tap(irq_tap), .ss_tap(ss_tap),
    .ana_sel(ana_sel)
  );

  AST_ANALOG_READ: assert property (@(posedge clk) disable iff (rst)
    (ana_sel && !bus_wr && bus_addr == SEL_PINS) |=> !bus_rdata[ANA_PIN]); // R8
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, pad_in, pad_out, pad_oe, pad_pu;
  logic       irq_tap, ss_tap, ana_sel;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .irq_tap(irq_tap), .ss_tap(ss_tap), .ana_sel(ana_sel)
  );

  // fields: dir, option, latch, expected oe, expected pu, expected out
  localparam logic [47:0] VEC [6] = '{
    {8'hCF, 8'h00, 8'hA5, 8'h30, 8'hCF, 8'hA5},
    {8'hCF, 8'h80, 8'h5A, 8'h30, 8'h00, 8'h5A},
    {8'h00, 8'h00, 8'h3C, 8'hFF, 8'h00, 8'h3C},
    {8'hFF, 8'h00, 8'hC3, 8'h00, 8'hFF, 8'hC3},
    {8'h0F, 8'h7F, 8'h81, 8'hF0, 8'h0F, 8'h81},
    {8'hF0, 8'hFF, 8'h18, 8'h0F, 8'h00, 8'h18}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pad_in = v;
    settle(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    pad_in = 8'h00;
    settle(3);
    rst = 1'b0;
    settle(1);

    // R1 reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_pu", pad_pu, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 ana_sel", {7'd0, ana_sel}, 8'h00);
    rd_reg(2'd1, rv); chk("R1 R6 dir read", rv, 8'hFF);
    rd_reg(2'd2, rv); chk("R5 option reset read", rv, 8'h80);

    // vector table: R2 R4 R5
    for (int i = 0; i < 6; i++) begin
      wr_reg(2'd1, VEC[i][47:40]);
      wr_reg(2'd2, VEC[i][39:32]);
      wr_reg(2'd0, VEC[i][31:24]);
      settle(1);
      chk("R2 pad_oe", pad_oe, VEC[i][23:16]);
      chk("R4 pad_pu", pad_pu, VEC[i][15:8]);
      chk("R2 pad_out", pad_out, VEC[i][7:0]);
      rd_reg(2'd1, rv); chk("R6 dir read", rv, VEC[i][47:40]);
      rd_reg(2'd2, rv); chk("R5 option read", rv, {VEC[i][39], 7'd0});
    end

    // R3 latch write on input pins, then switch to output
    wr_reg(2'd1, 8'hFF);
    wr_reg(2'd0, 8'h55);
    settle(1);
    chk("R3 oe while input", pad_oe, 8'h00);
    wr_reg(2'd1, 8'h00);
    settle(1);
    chk("R3 oe after switch", pad_oe, 8'hFF);
    chk("R3 out after switch", pad_out, 8'h55);

    // R9 pad update one edge after register write
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 8'hFF; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R9 pad lag", pad_oe, 8'hFF);
    @(negedge clk);
    chk("R9 pad updated", pad_oe, 8'h00);

    // R6 port read returns pins, not latch
    set_pins(8'h96);
    rd_reg(2'd0, rv); chk("R6 pin read", rv, 8'h96);

    // R7 taps
    set_pins(8'h01);
    chk("R7 irq high", {7'd0, irq_tap}, 8'h01);
    chk("R7 ss low", {7'd0, ss_tap}, 8'h00);
    set_pins(8'h02);
    chk("R7 irq low", {7'd0, irq_tap}, 8'h00);
    chk("R7 ss high", {7'd0, ss_tap}, 8'h01);

    // R8 analog mode masks pin 2
    wr_reg(2'd3, 8'h01);
    set_pins(8'hFF);
    chk("R8 ana_sel", {7'd0, ana_sel}, 8'h01);
    rd_reg(2'd0, rv); chk("R8 masked read", rv, 8'hFB);
    rd_reg(2'd3, rv); chk("R6 R8 analog read", rv, 8'h01);
    wr_reg(2'd3, 8'h00);
    rd_reg(2'd0, rv); chk("R8 unmasked read", rv, 8'hFF);

    // R1 reset again after activity
    wr_reg(2'd2, 8'h00);
    @(negedge clk); rst = 1'b1;
    settle(2); rst = 1'b0;
    settle(1);
    chk("R1 pu after reset", pad_pu, 8'h00);
    chk("R1 oe after reset", pad_oe, 8'h00);
    rd_reg(2'd2, rv); chk("R5 option after reset", rv, 8'h80);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule